// File: doc/BRIEF.md
# Bus Cycle Status Encoder

The encoder turns the bus unit's view of the current transfer into the three active-low status lines and the DMA status line that external logic decodes. The bus unit tells it what kind of cycle it is running, whether a DMA channel started that cycle, and which T-state the bus enters at the next clock edge. The encoder also receives the bus-hold and hold-acknowledge conditions. All outputs are registered, so they line up with the T-state the bus is in.

The status code is valid during T1 and T2 and falls back to the passive code during T3, T4 and idle. The cycle kind and the DMA flag are captured when the bus enters T1, so they stay fixed for the whole cycle. The output-enable signals stand in for tristate control: the status code floats during hold, and the DMA line floats during hold and reset.

Top module: `bus_status_enc`

## Requirements
- R1: Input kind encodings 6 (interrupt acknowledge), 4 (I/O read), 5 (I/O write) and 7 (halt) produce stat_n_o codes 000, 001, 010 and 011 during T1 and T2.
- R2: Input kind encodings 1 (instruction fetch), 2 (memory read), 3 (memory write) and 0 (passive) produce stat_n_o codes 100, 101, 110 and 111 during T1 and T2.
- R3: The code shown in T2 is the kind captured when t_next_i was 1 (T1). Changes on kind_i after that have no effect until the next T1.
- R4: When t_next_i is 0 (idle), 3 (T3), 4 (T4) or any other value, stat_n_o is 111 after the next edge.
- R5: When bus_hold_i or hold_ack_i is high at an edge, stat_oe_o is low and stat_n_o is 111 after that edge. Otherwise stat_oe_o is high.
- R6: dma_stat_o is high after an edge with t_next_i of 2, 3 or 4 (T2 to T4), provided dma_req_i was high when T1 was entered. It is low in T1, in idle and in cycles not started by DMA.
- R7: dma_oe_o is low after an edge where rst, bus_hold_i or hold_ack_i is high, and dma_stat_o is then 0. Otherwise dma_oe_o is high.
- R8: After reset: stat_n_o=111, stat_oe_o=1, dma_stat_o=0, dma_oe_o=0.
- R9: Outputs change only at a rising clock edge. A change on the inputs does not appear before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kind_i | input | 3 | Requested cycle kind |
| dma_req_i | input | 1 | Cycle is DMA-initiated |
| t_next_i | input | 3 | T-state entered at the next edge (0 idle, 1..4 T1..T4) |
| bus_hold_i | input | 1 | Bus hold in effect |
| hold_ack_i | input | 1 | Hold acknowledge in effect |
| stat_n_o | output | 3 | Active-low status code |
| stat_oe_o | output | 1 | Drive enable for stat_n_o |
| dma_stat_o | output | 1 | DMA status bit |
| dma_oe_o | output | 1 | Drive enable for dma_stat_o |

## Verification
The assertions assume that t_next_i follows a legal order: idle, then T1, T2, T3, T4, and back to idle or T1. They also assume kind_i and dma_req_i are meaningful only when T1 is entered. The random stimulus builds whole bus cycles in that order, with random idle gaps and random hold windows. Within those cycles it changes kind_i and dma_req_i after T1 so that the capture rule is tested. Directed cases cover every kind code, reset in the middle of a cycle, and the input-to-output latency.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    localparam int CODE_W = 3;
    localparam int TST_W  = 3;

    typedef enum logic [2:0] {
        K_PASSIVE = 3'd0,
        K_FETCH   = 3'd1,
        K_MEM_RD  = 3'd2,
        K_MEM_WR  = 3'd3,
        K_IO_RD   = 3'd4,
        K_IO_WR   = 3'd5,
        K_INTA    = 3'd6,
        K_HALT    = 3'd7
    } kind_e;

    typedef enum logic [2:0] {
        TS_IDLE = 3'd0,
        TS_T1   = 3'd1,
        TS_T2   = 3'd2,
        TS_T3   = 3'd3,
        TS_T4   = 3'd4
    } tstate_e;

    localparam logic [CODE_W-1:0] CODE_PASSIVE = 3'b111;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              oe;
    } stat_out_t;

    typedef struct packed {
        logic bit_v;
        logic oe;
    } dma_out_t;

    // Bit 2: memory (1) versus I/O (0); bit 1: write (1) versus read (0).
    function automatic logic [CODE_W-1:0] kind_to_code(input logic [2:0] k);
        logic [CODE_W-1:0] c;
        case (k)
            K_INTA:   c = 3'b000;
            K_IO_RD:  c = 3'b001;
            K_IO_WR:  c = 3'b010;
            K_HALT:   c = 3'b011;
            K_FETCH:  c = 3'b100;
            K_MEM_RD: c = 3'b101;
            K_MEM_WR: c = 3'b110;
            default:  c = CODE_PASSIVE;
        endcase
        return c;
    endfunction

    function automatic logic in_data_phase(input logic [TST_W-1:0] t);
        return (t == TS_T2) || (t == TS_T3) || (t == TS_T4);
    endfunction

endpackage

// File: rtl/bsc_enable_stage.sv
module bsc_enable_stage (
    input  logic clk,
    input  logic rst,
    input  logic bus_hold_i,
    input  logic hold_ack_i,
    output logic stat_oe_o,
    output logic dma_oe_o,
    output logic held_o
);
    logic held;
    assign held   = bus_hold_i || hold_ack_i;
    assign held_o = held;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_oe_o <= 1'b1;
            dma_oe_o  <= 1'b0;
        end else begin
            stat_oe_o <= !held;
            dma_oe_o  <= !held;
        end
    end

    assert_hold_float_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_hold_i || hold_ack_i) |=> !stat_oe_o);
    assert_reset_float_R7: assert property (@(posedge clk)
        rst |=> !dma_oe_o);
endmodule

// File: rtl/bsc_code_stage.sv
module bsc_code_stage
    import bsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        kind_i,
    input  logic [TST_W-1:0]  t_next_i,
    input  logic              held_i,
    output logic [CODE_W-1:0] code_o
);
    logic [2:0]        kind_q;
    logic [CODE_W-1:0] code_d;

    always_comb begin
        code_d = CODE_PASSIVE;
        if (!held_i) begin
            if (t_next_i == TS_T1)      code_d = kind_to_code(kind_i);
            else if (t_next_i == TS_T2) code_d = kind_to_code(kind_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= K_PASSIVE;
            code_o <= CODE_PASSIVE;
        end else begin
            if (t_next_i == TS_T1) kind_q <= kind_i;
            code_o <= code_d;
        end
    end

    assert_late_passive_R4: assert property (@(posedge clk) disable iff (rst)
        (t_next_i != TS_T1 && t_next_i != TS_T2) |=> (code_o == CODE_PASSIVE));
    assert_hold_passive_R5: assert property (@(posedge clk) disable iff (rst)
        held_i |=> (code_o == CODE_PASSIVE));
endmodule

// File: rtl/bsc_dma_stage.sv
module bsc_dma_stage
    import bsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             dma_req_i,
    input  logic [TST_W-1:0] t_next_i,
    input  logic             held_i,
    output logic             dma_o
);
    logic dma_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dma_q <= 1'b0;
            dma_o <= 1'b0;
        end else begin
            if (t_next_i == TS_T1) dma_q <= dma_req_i;
            dma_o <= !held_i && dma_q && in_data_phase(t_next_i);
        end
    end

    assert_t1_low_R6: assert property (@(posedge clk) disable iff (rst)
        (t_next_i == TS_T1) |=> !dma_o);
    assert_hold_low_R7: assert property (@(posedge clk) disable iff (rst)
        held_i |=> !dma_o);
endmodule

// File: rtl/bus_status_enc.sv
module bus_status_enc
    import bsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] kind_i,
    input  logic       dma_req_i,
    input  logic [2:0] t_next_i,
    input  logic       bus_hold_i,
    input  logic       hold_ack_i,
    output logic [2:0] stat_n_o,
    output logic       stat_oe_o,
    output logic       dma_stat_o,
    output logic       dma_oe_o
);
    logic      held;
    stat_out_t stat_s;
    dma_out_t  dma_s;

    bsc_enable_stage en_i (
        .clk(clk), .rst(rst),
        .bus_hold_i(bus_hold_i), .hold_ack_i(hold_ack_i),
        .stat_oe_o(stat_s.oe), .dma_oe_o(dma_s.oe), .held_o(held)
    );

    bsc_code_stage code_i (
        .clk(clk), .rst(rst), .kind_i(kind_i), .t_next_i(t_next_i),
        .held_i(held), .code_o(stat_s.code)
    );

    bsc_dma_stage dma_i (
        .clk(clk), .rst(rst), .dma_req_i(dma_req_i), .t_next_i(t_next_i),
        .held_i(held), .dma_o(dma_s.bit_v)
    );

    assign stat_n_o   = stat_s.code;
    assign stat_oe_o  = stat_s.oe;
    assign dma_stat_o = dma_s.bit_v;
    assign dma_oe_o   = dma_s.oe;

    assert_dma_needs_drive_R7: assert property (@(posedge clk) disable iff (rst)
        dma_stat_o |-> dma_oe_o);
endmodule

// File: tb/bus_status_enc_tb_top.sv
module bus_status_enc_tb_top;
    logic clk = 1'b0;
    logic rst;
    logic [2:0] kind_i, t_next_i, stat_n_o;
    logic dma_req_i, bus_hold_i, hold_ack_i, stat_oe_o, dma_stat_o, dma_oe_o;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    // model state
    logic [2:0] m_kind;
    logic       m_dma;
    logic [2:0] e_code;
    logic       e_soe, e_dma, e_doe;

    always #5 clk = ~clk;

    bus_status_enc dut_i (.*);

    function automatic logic [2:0] ref_code(input logic [2:0] k);
        case (k)
            3'd6: return 3'b000;
            3'd4: return 3'b001;
            3'd5: return 3'b010;
            3'd7: return 3'b011;
            3'd1: return 3'b100;
            3'd2: return 3'b101;
            3'd3: return 3'b110;
            default: return 3'b111;
        endcase
    endfunction

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // called at negedge: drive, update model, wait edge, check at next negedge
    task automatic step(input logic [2:0] k, input logic d, input logic [2:0] t,
                        input logic h, input logic a);
        logic held;
        string sreq;
        kind_i = k; dma_req_i = d; t_next_i = t; bus_hold_i = h; hold_ack_i = a;
        held = h | a;
        e_soe = !held; e_doe = !held;
        e_code = 3'b111;
        sreq = "R4";
        if (held) sreq = "R5";
        else if (t == 3'd1) begin
            e_code = ref_code(k);
            sreq = e_code[2] ? "R2" : "R1";
        end else if (t == 3'd2) begin
            e_code = ref_code(m_kind);
            sreq = "R3";
        end
        e_dma = !held && ((t == 3'd1) ? 1'b0 : (m_dma && (t >= 3'd2 && t <= 3'd4)));
        if (t == 3'd1) begin m_kind = k; m_dma = d; end
        @(posedge clk); #1;
        @(negedge clk);
        chk(sreq, {1'b0, stat_n_o}, {1'b0, e_code});
        chk("R5", {3'b0, stat_oe_o}, {3'b0, e_soe});
        chk("R6", {3'b0, dma_stat_o}, {3'b0, e_dma});
        chk("R7", {3'b0, dma_oe_o}, {3'b0, e_doe});
    endtask

    task automatic do_reset;
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R8", {stat_n_o, stat_oe_o}, {3'b111, 1'b1});
        chk("R8", {2'b0, dma_stat_o, dma_oe_o}, 4'b0000);
        chk("R7", {3'b0, dma_oe_o}, 4'b0);
        rst = 1'b0;
        m_kind = 3'd0; m_dma = 1'b0;
    endtask

    initial begin
        #200000;
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int unused;
        unused = $urandom(32'h5eed_1234);
        kind_i = 0; dma_req_i = 0; t_next_i = 0; bus_hold_i = 0; hold_ack_i = 0;
        rst = 1'b1;
        @(negedge clk);
        do_reset();
        // directed: every kind, DMA on odd kinds, R1/R2/R6
        for (int k = 0; k < 8; k++) begin
            step(3'(k), k[0], 3'd1, 0, 0);
            step(3'(k + 3), !k[0], 3'd2, 0, 0);   // kind change ignored: R3
            step(3'(k), 0, 3'd3, 0, 0);
            step(3'(k), 0, 3'd4, 0, 0);
            step(3'(k), 0, 3'd0, 0, 0);
        end
        // R9: input change not visible before the edge
        step(3'd1, 0, 3'd0, 0, 0);
        kind_i = 3'd6; t_next_i = 3'd1; #2;
        chk("R9", {1'b0, stat_n_o}, 4'h7);
        @(posedge clk); #1;
        chk("R9", {1'b0, stat_n_o}, 4'h0);
        @(negedge clk);
        m_kind = 3'd6; m_dma = 1'b0;
        // hold in mid-cycle then resume
        step(3'd3, 1, 3'd1, 0, 0);
        step(3'd3, 1, 3'd2, 1, 0);
        step(3'd3, 1, 3'd3, 0, 1);
        step(3'd3, 1, 3'd4, 0, 0);
        step(3'd0, 0, 3'd7, 0, 0);          // undefined T-state: R4
        // reset in the middle of a DMA cycle
        step(3'd2, 1, 3'd1, 0, 0);
        step(3'd2, 1, 3'd2, 0, 0);
        do_reset();
        // random whole cycles
        for (int c = 0; c < 400; c++) begin
            logic [2:0] k;
            logic d;
            int gap;
            k = 3'($urandom_range(0, 7));
            d = 1'($urandom_range(0, 1));
            gap = $urandom_range(0, 2);
            for (int g = 0; g < gap; g++)
                step(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 3'd0,
                     ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0));
            for (int t = 1; t <= 4; t++)
                step((t == 1) ? k : 3'($urandom_range(0, 7)),
                     (t == 1) ? d : 1'($urandom_range(0, 1)), 3'(t),
                     ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0));
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule